// File: doc/BRIEF.md
# SMBus Target Front End with Strap-Selected Address

This block is the bus-facing half of an SMBus 2.0 target. It samples the SCL and SDA lines through synchronizers and glitch filters, detects START and STOP, shifts the address byte in and decides whether to acknowledge. It does not have a fixed address. Two board straps, an enable strap and a select strap, encode one of three addresses. That address is captured once, at the first transaction whose address byte carries the family prefix `01011` in its top five bits. Traffic to other addresses never captures it.

Once the first acknowledged transaction has ended with a STOP, a sticky release flag tells the surrounding chip that the strap pins may return to their normal fan duties. After the address is locked, only the exact 7-bit address is acknowledged.

Data bytes are passed to a register file through single-cycle strobes: a write strobe carrying the data, a read request that asks for the next byte, and a STOP strobe. Either line held low for too long resets the protocol engine and releases SDA.

Top module: `smbus_strap_target`

## Requirements
- R1: Out of reset, `sda_oe_o`, `strap_release_o` and `addr_locked_o` are all 0, so the straps stay inputs and SDA is released.
- R2: The strap address is 0x2E when `strap_en_i`=1, whatever `strap_sel_i` is. It is 0x2C when `strap_en_i`=0 and `strap_sel_i`=0, and 0x2D when `strap_en_i`=0 and `strap_sel_i`=1. `addr_o` shows the locked value.
- R3: The address is locked only by an address byte whose bits [7:3] equal 01011 (bits [7:1] are the address, bit 0 is R/W with 1 meaning read). An address byte with any other prefix is NACKed and leaves `addr_locked_o` at 0.
- R4: Once locked, `addr_o` ignores later strap changes. An address byte is ACKed (SDA pulled low in the ninth bit) only if its 7 address bits equal the locked address. This also applies in the transaction that performs the lock.
- R5: In a write, every data byte is ACKed. Its bits are received MSB first, and `wr_valid_o` pulses for one cycle with the byte on `wr_data_o`.
- R6: In a read, `rd_req_o` pulses once after the address ACK and once after each master ACK. `rd_data_i` is shifted out MSB first, with SDA driven low only for 0 bits. A master NACK ends the transfer with SDA released.
- R7: A STOP that ends an ACKed transaction pulses `stop_o`. The first such STOP sets `strap_release_o`, which then stays 1. A STOP after a NACKed address does neither.
- R8: If SCL or SDA stays low for `TIMEOUT_CYC` clock cycles, the engine returns to idle and releases SDA. The next transaction is served normally.
- R9: A pulse on SCL shorter than `FILT_LEN` clock cycles is not counted as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_en_i | input | 1 | Address enable strap |
| strap_sel_i | input | 1 | Address select strap |
| strap_release_o | output | 1 | Sticky: strap pins may return to fan use |
| addr_locked_o | output | 1 | Address has been captured |
| addr_o | output | 7 | Locked 7-bit address |
| wr_valid_o | output | 1 | One-cycle write-data strobe |
| wr_data_o | output | 8 | Received data byte |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Read byte from the register file |
| stop_o | output | 1 | One-cycle STOP strobe for an ACKed transaction |

## Verification
Two functions share one cycle when the first prefix-matching address byte also mismatches the strap address. The lock is captured and the acknowledge is refused at the same SCL fall. The bench provokes this by sending 0x2C with the straps decoding 0x2E. It expects a NACK together with `addr_o`=0x2E, and then an ACK for 0x2E. The STOP strobe and the first rise of the release flag also coincide. The bench judges this by the STOP count and the release level checked together after the first acknowledged transaction.

// File: rtl/smbus_pkg.sv
package smbus_pkg;

  localparam logic [4:0] ADDR_PREFIX = 5'b01011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_e;

  function automatic logic [6:0] strap_decode(input logic en, input logic sel);
    if (en) strap_decode = 7'h2E;
    else if (sel) strap_decode = 7'h2D;
    else strap_decode = 7'h2C;
  endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                out_q, out_d;

  always_comb begin
    hist_d = {hist_q[FILT_LEN-2:0], sync_q[1]};
    out_d  = out_q;
    if (&hist_q) out_d = 1'b1;
    else if (~|hist_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/low_timer.sv
module low_timer #(
  parameter int LIMIT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = '0;
    if (!line_i) cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
    exp_d = !line_i && (cnt_q == LIM - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

endmodule

// File: rtl/target_fsm.sv
module target_fsm
  import smbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       timeout,
  input  logic [6:0] strap_addr,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       release_o,
  output logic       locked_o,
  output logic [6:0] addr_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_data_o,
  output logic       rd_req_o,
  output logic       stop_o
);

  bus_state_e st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       scl_p, sda_p;
  logic       oe_q, oe_d, ack_q, ack_d, rw_q, rw_d, sess_q, sess_d;
  logic       lock_q, lock_d, rel_q, rel_d, mnack_q, mnack_d;
  logic [6:0] addr_q, addr_d;
  logic       wr_q, wr_d, rdq_q, rdq_d, stp_q, stp_d;
  logic [7:0] wdat_q, wdat_d;
  logic       start_ev, stop_ev, rise_ev, fall_ev, prefix_ok, hit;

  assign start_ev  = scl_f && scl_p && sda_p && !sda_f;
  assign stop_ev   = scl_f && scl_p && !sda_p && sda_f;
  assign rise_ev   = scl_f && !scl_p;
  assign fall_ev   = !scl_f && scl_p;
  assign prefix_ok = (sh_q[7:3] == ADDR_PREFIX);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; oe_d = oe_q; ack_d = ack_q;
    rw_d = rw_q; sess_d = sess_q; lock_d = lock_q; rel_d = rel_q;
    mnack_d = mnack_q; addr_d = addr_q; wdat_d = wdat_q;
    wr_d = 1'b0; rdq_d = 1'b0; stp_d = 1'b0;
    hit = 1'b0;
    if (timeout) begin
      st_d = ST_IDLE; oe_d = 1'b0; sess_d = 1'b0;
    end else if (start_ev) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_ev) begin
      st_d = ST_IDLE; oe_d = 1'b0; sess_d = 1'b0;
      if (sess_q) begin
        stp_d = 1'b1; rel_d = 1'b1;
      end
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR: begin
          if (rise_ev && cnt_q != 4'd8) begin
            sh_d = {sh_q[6:0], sda_f}; cnt_d = cnt_q + 4'd1;
          end else if (fall_ev && cnt_q == 4'd8) begin
            if (st_q == ST_WR) begin
              wr_d = 1'b1; wdat_d = sh_q; oe_d = 1'b1; st_d = ST_WR_ACK;
            end else begin
              if (lock_q) hit = (sh_q[7:1] == addr_q);
              else begin
                hit = prefix_ok && (sh_q[7:1] == strap_addr);
                if (prefix_ok) begin
                  lock_d = 1'b1; addr_d = strap_addr;
                end
              end
              ack_d = hit; oe_d = hit; rw_d = sh_q[0];
              if (hit) sess_d = 1'b1;
              if (hit && sh_q[0]) rdq_d = 1'b1;
              st_d = ST_ADDR_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (fall_ev) begin
          cnt_d = '0;
          if (!ack_q) begin
            st_d = ST_IDLE; oe_d = 1'b0;
          end else if (rw_q) begin
            st_d = ST_RD; sh_d = rd_data_i; oe_d = !rd_data_i[7];
          end else begin
            st_d = ST_WR; oe_d = 1'b0;
          end
        end
        ST_WR_ACK: if (fall_ev) begin
          st_d = ST_WR; oe_d = 1'b0; cnt_d = '0;
        end
        ST_RD: if (fall_ev) begin
          if (cnt_q == 4'd7) begin
            st_d = ST_RD_ACK; oe_d = 1'b0;
          end else begin
            sh_d = {sh_q[6:0], 1'b0}; oe_d = !sh_q[6]; cnt_d = cnt_q + 4'd1;
          end
        end
        ST_RD_ACK: begin
          if (rise_ev) begin
            mnack_d = sda_f;
            if (!sda_f) rdq_d = 1'b1;
          end else if (fall_ev) begin
            cnt_d = '0;
            if (mnack_q) st_d = ST_IDLE;
            else begin
              st_d = ST_RD; sh_d = rd_data_i; oe_d = !rd_data_i[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; scl_p <= 1'b1; sda_p <= 1'b1;
      oe_q <= 1'b0; ack_q <= 1'b0; rw_q <= 1'b0; sess_q <= 1'b0;
      lock_q <= 1'b0; rel_q <= 1'b0; mnack_q <= 1'b0; addr_q <= '0;
      wr_q <= 1'b0; rdq_q <= 1'b0; stp_q <= 1'b0; wdat_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; scl_p <= scl_f; sda_p <= sda_f;
      oe_q <= oe_d; ack_q <= ack_d; rw_q <= rw_d; sess_q <= sess_d;
      lock_q <= lock_d; rel_q <= rel_d; mnack_q <= mnack_d; addr_q <= addr_d;
      wr_q <= wr_d; rdq_q <= rdq_d; stp_q <= stp_d; wdat_q <= wdat_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign release_o  = rel_q;
  assign locked_o   = lock_q;
  assign addr_o     = addr_q;
  assign wr_valid_o = wr_q;
  assign wr_data_o  = wdat_q;
  assign rd_req_o   = rdq_q;
  assign stop_o     = stp_q;

  // R8: an expired line timer releases SDA on the next cycle
  a_r8_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !oe_q);
  // R7: the release flag never falls
  a_r7_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> rel_q);
  // R4: a locked address never changes
  a_r4_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q && $stable(addr_q));
  // R3: the lock is taken only from a prefix-matching address byte
  a_r3_lock_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(sh_q[7:3]) == ADDR_PREFIX);
  // R5: the write strobe lasts one cycle
  a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);
  // R6: SDA is pulled low only in acknowledge slots or while sending data
  a_r6_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q == ST_ADDR_ACK || st_q == ST_WR_ACK || st_q == ST_RD));

endmodule

// File: rtl/smbus_strap_target.sv
module smbus_strap_target
  import smbus_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       strap_en_i,
  input  logic       strap_sel_i,
  output logic       strap_release_o,
  output logic       addr_locked_o,
  output logic [6:0] addr_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_data_o,
  output logic       rd_req_o,
  input  logic [7:0] rd_data_i,
  output logic       stop_o
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt, expired;
  logic [6:0]        strap_addr;

  assign raw        = {sda_i, scl_i};
  assign strap_addr = strap_decode(strap_en_i, strap_sel_i);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g]));
    low_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .line_i(filt[g]), .expired_o(expired[g]));
  end

  target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_f(filt[0]), .sda_f(filt[1]),
    .timeout(|expired), .strap_addr(strap_addr), .rd_data_i(rd_data_i),
    .sda_oe_o(sda_oe_o), .release_o(strap_release_o), .locked_o(addr_locked_o),
    .addr_o(addr_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .rd_req_o(rd_req_o), .stop_o(stop_o));

endmodule

// File: tb/smbus_strap_target_tb.sv
module smbus_strap_target_tb;

  localparam int TO = 600;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic en = 1'b0, sel = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, release_o, locked, wr_valid, rd_req, stop_s;
  logic [6:0] addr;
  logic [7:0] wr_data;
  logic sda_line;

  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0, stop_cnt = 0;
  logic [7:0] wr_last = 8'h00;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smbus_strap_target #(.FILT_LEN(3), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_en_i(en), .strap_sel_i(sel), .strap_release_o(release_o),
    .addr_locked_o(locked), .addr_o(addr), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_data_i(rd_data), .stop_o(stop_s));

  always @(posedge clk) begin
    if (wr_valid) begin wr_cnt <= wr_cnt + 1; wr_last <= wr_data; end
    if (rd_req) rd_cnt <= rd_cnt + 1;
    if (stop_s) stop_cnt <= stop_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic e, input logic s);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; en = e; sel = s;
    wait_clk(5); rst_n = 1'b1; wait_clk(10);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    if (glitch) begin
      wait_clk(2); scl_m = 1'b1; wait_clk(2); scl_m = 1'b0; wait_clk(Q - 4);
    end else wait_clk(Q);
    sda_m = b; wait_clk(Q);
    scl_m = 1'b1; wait_clk(2 * Q);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_clk(Q); sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    b = sda_line; wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch && i == 4);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b1);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(release_o == 1'b0, "R1 release", release_o, 0);
    chk(locked == 1'b0, "R1 locked", locked, 0);
  endtask

  task automatic t_foreign();
    logic a;
    bus_start(); put_byte(8'h90, 1'b0, a); bus_stop();
    chk(a == 1'b1, "R3 foreign nack", a, 1);
    chk(locked == 1'b0, "R3 not locked", locked, 0);
    chk(release_o == 1'b0, "R7 no release after nack", release_o, 0);
    chk(stop_cnt == 0, "R7 no stop strobe", stop_cnt, 0);
  endtask

  task automatic t_first_write();
    logic a;
    bus_start(); put_byte(8'h5A, 1'b0, a);
    chk(a == 1'b0, "R4 address ack", a, 0);
    chk(locked == 1'b1, "R3 locked", locked, 1);
    chk(addr == 7'h2D, "R2 addr 2D", addr, 'h2D);
    put_byte(8'hA5, 1'b0, a);
    chk(a == 1'b0, "R5 data ack", a, 0);
    chk(wr_last == 8'hA5 && wr_cnt == 1, "R5 wr strobe", wr_last, 'hA5);
    put_byte(8'h00, 1'b1, a);
    chk(a == 1'b0, "R9 ack despite glitch", a, 0);
    chk(wr_last == 8'h00 && wr_cnt == 2, "R9 byte after glitch", wr_last, 0);
    bus_stop();
    chk(release_o == 1'b1, "R7 release", release_o, 1);
    chk(stop_cnt == 1, "R7 stop strobe", stop_cnt, 1);
  endtask

  task automatic t_strap_ignored();
    logic a;
    en = 1'b1;
    bus_start(); put_byte(8'h5C, 1'b0, a); bus_stop();
    chk(a == 1'b1, "R4 other address nack", a, 1);
    chk(addr == 7'h2D, "R4 addr kept", addr, 'h2D);
    chk(release_o == 1'b1, "R7 release sticky", release_o, 1);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    rd_data = 8'h96;
    bus_start(); put_byte(8'h5B, 1'b0, a);
    chk(a == 1'b0, "R6 read address ack", a, 0);
    chk(rd_cnt == 1, "R6 first rd_req", rd_cnt, 1);
    get_byte(d);
    chk(d == 8'h96, "R6 first byte", d, 'h96);
    rd_data = 8'h3C;
    put_bit(1'b0, 1'b0);
    chk(rd_cnt == 2, "R6 second rd_req", rd_cnt, 2);
    get_byte(d);
    chk(d == 8'h3C, "R6 second byte", d, 'h3C);
    put_bit(1'b1, 1'b0);
    wait_clk(Q + 4);
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    chk(rd_cnt == 2, "R6 no request after nack", rd_cnt, 2);
    bus_stop();
  endtask

  task automatic t_timeout();
    logic a;
    int s0;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(8'h5A >> i, 1'b0);
    wait_clk(12);
    chk(sda_oe == 1'b1, "R8 ack driven before timeout", sda_oe, 1);
    wait_clk(TO + 40);
    chk(sda_oe == 1'b0, "R8 released by timeout", sda_oe, 0);
    s0 = stop_cnt;
    sda_m = 1'b1;
    bus_stop();
    chk(stop_cnt == s0, "R8 session cleared", stop_cnt, s0);
    bus_start(); put_byte(8'h5A, 1'b0, a); bus_stop();
    chk(a == 1'b0, "R8 served after timeout", a, 0);
  endtask

  task automatic t_decode_2c();
    logic a;
    do_reset(1'b0, 1'b0);
    bus_start(); put_byte(8'h58, 1'b0, a); bus_stop();
    chk(a == 1'b0 && addr == 7'h2C, "R2 addr 2C", addr, 'h2C);
  endtask

  task automatic t_mismatch_lock();
    logic a;
    do_reset(1'b1, 1'b0);
    bus_start(); put_byte(8'h58, 1'b0, a); bus_stop();
    chk(a == 1'b1, "R4 nack on strap mismatch", a, 1);
    chk(locked == 1'b1 && addr == 7'h2E, "R2 addr 2E locked", addr, 'h2E);
    chk(release_o == 1'b0, "R7 no release yet", release_o, 0);
    bus_start(); put_byte(8'h5C, 1'b0, a); bus_stop();
    chk(a == 1'b0, "R4 ack on locked address", a, 0);
    chk(release_o == 1'b1, "R7 release after ack", release_o, 1);
  endtask

  initial begin
    t_reset();
    t_foreign();
    t_first_write();
    t_strap_ignored();
    t_read();
    t_timeout();
    t_decode_2c();
    t_mismatch_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule